// File: doc/BRIEF.md
# Multicycle Three-Address Word Processor Core

This block is a 32-bit processor core with no flag register. It addresses memory in words and has 32 general registers, of which register 0 always reads as zero. Every instruction is one 32-bit word laid out as opcode in bits [31:26], first register field A in bits [25:21], second register field B in bits [20:16] and a 16-bit field D in bits [15:0]. Depending on the opcode, D carries a third register number in D[4:0], an absolute address, a displacement or an immediate. Comparison instructions write 0 or 1 into a register. Two conditional jumps then test a register for zero or nonzero.

The core runs one instruction at a time through the states fetch, decode, execute, memory and writeback. Pop needs one more writeback cycle. It drives a single synchronous word memory, which returns read data one cycle after the address is presented. A trap instruction either stops the core or publishes a register value on a one-cycle print strobe. Opcodes that are not defined behave as no-ops and set a sticky flag.

Top module: `tri_addr_core`

## Requirements
- R1: While reset is held and after its release, PC is 0 and the core presents address 0. `halted`, `illegal_op`, `print_valid` and `mem_we` are all low.
- R2: An instruction occupies 5 cycles from the start of its fetch to the start of the next fetch, and pop occupies 6. A print strobe or store write comes in the fourth cycle of its instruction.
- R3: Register 0 reads as zero. A write to register 0, for example add with A=0, leaves it at zero.
- R4: ALU opcodes 10..25 use the sign-extended D as the second operand. Opcodes 32..47 use register D[4:0]. The operation index is (opcode-10) or (opcode-32): 0 add, 1 sub, 2 mul (low 32 bits), 3 div, 4 and, 5 or, 6 xor, 7 eq, 8 ne, 9 lt, 10 le, 11 gt, 12 ge, 13 shift left, 14 logical shift right, 15 mod. The result goes to register A, and the first operand is register B.
- R5: The comparisons (indices 7..12) are signed two's complement and write exactly 1 for true and 0 for false.
- R6: Division truncates toward zero. Division by zero gives 0, and mod by zero gives the dividend. A divisor of -1 gives the negated dividend and remainder 0. A shift amount is the whole unsigned operand, and an amount of 32 or more gives 0.
- R7: Loads write register A. Opcode 1 reads M[zero-extended D], opcode 2 reads M[sign-extended D + R[B]] and opcode 48 reads M[R[B] + R[D[4:0]]].
- R8: Stores write R[A]. Opcode 3 writes to the zero-extended D, opcode 4 to sign-extended D + R[B], and opcode 49 to R[B] + R[D[4:0]]. `mem_we` is high for exactly one cycle per store, with the address and data valid in that cycle.
- R9: Opcode 6 jumps to the zero-extended D. Opcode 8 jumps there when R[A] is nonzero and opcode 9 when R[A] is zero. Opcode 7 writes PC+1 into R[A] and jumps. Opcode 50 sets PC to R[A]. Any other instruction continues at PC+1.
- R10: Push (52) first increments R[A] and then stores R[B] at the new R[A]. Pop (53) loads M[R[A]] into R[B] and then decrements R[A].
- R11: Trap (51) with D=0 halts the core. The core then fetches nothing more, writes nothing, holds its address and keeps `halted` high. Trap with D=1 raises `print_valid` for one cycle with R[A] on `print_data`. Any other D is a no-op.
- R12: Opcodes 0 and 5 are no-ops. Opcodes 26..31 and 54..63 change no register and set `illegal_op`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Word address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Core stopped by trap 0 |
| print_valid | output | 1 | One-cycle print strobe |
| print_data | output | 32 | Value being printed |
| illegal_op | output | 1 | Sticky undefined-opcode flag |

## Verification
The test program routes its results through trap prints and stores. A print strobe and a store write both appear in the fourth cycle of their instruction, counted from the start of its fetch. The monitor therefore compares each strobe with the next queued item at the falling edge of that cycle and never waits a fixed delay. Spacing is checked by counting cycles between strobes. Two single-cycle-count instructions give 10 cycles, adjacent traps give 5, and a trap followed by a pop and a trap gives 11. After the halt, a window of idle cycles confirms that no print or write occurs and that the address holds still.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int DLEN  = 16;

  localparam logic [5:0] OP_LD_ABS = 6'd1;
  localparam logic [5:0] OP_LD_DSP = 6'd2;
  localparam logic [5:0] OP_ST_ABS = 6'd3;
  localparam logic [5:0] OP_ST_DSP = 6'd4;
  localparam logic [5:0] OP_JMP    = 6'd6;
  localparam logic [5:0] OP_JAL    = 6'd7;
  localparam logic [5:0] OP_JT     = 6'd8;
  localparam logic [5:0] OP_JF     = 6'd9;
  localparam logic [5:0] OP_LD_IDX = 6'd48;
  localparam logic [5:0] OP_ST_IDX = 6'd49;
  localparam logic [5:0] OP_RET    = 6'd50;
  localparam logic [5:0] OP_TRAP   = 6'd51;
  localparam logic [5:0] OP_PUSH   = 6'd52;
  localparam logic [5:0] OP_POP    = 6'd53;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_WB2, S_HALT
  } state_t;

  typedef enum logic [1:0] {AM_ABS, AM_DISP, AM_IDX, AM_STACK} amode_t;

  typedef struct packed {
    logic       alu;
    logic [3:0] alu_sel;
    logic       use_imm;
    logic       load;
    logic       store;
    amode_t     amode;
    logic       jmp;
    logic       jal;
    logic       jt;
    logic       jf;
    logic       ret;
    logic       push;
    logic       pop;
    logic       trap;
    logic       bad;
  } ctl_t;

  function automatic logic [XLEN-1:0] alu_fn(input logic [3:0] sel,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    logic signed [XLEN-1:0] sa, sb;
    logic [XLEN-1:0] y;
    sa = $signed(a);
    sb = $signed(b);
    y  = '0;
    case (sel)
      4'd0:  y = a + b;
      4'd1:  y = a - b;
      4'd2:  y = a * b;
      4'd3:  y = (b == '0) ? '0 : (b == '1) ? ('0 - a) : XLEN'(sa / sb);
      4'd4:  y = a & b;
      4'd5:  y = a | b;
      4'd6:  y = a ^ b;
      4'd7:  y = XLEN'(a == b);
      4'd8:  y = XLEN'(a != b);
      4'd9:  y = XLEN'(sa < sb);
      4'd10: y = XLEN'(sa <= sb);
      4'd11: y = XLEN'(sa > sb);
      4'd12: y = XLEN'(sa >= sb);
      4'd13: y = a << b;
      4'd14: y = a >> b;
      default: y = (b == '0) ? a : (b == '1) ? '0 : XLEN'(sa % sb);
    endcase
    return y;
  endfunction
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] op,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.amode = AM_ABS;
    if (op >= 6'd10 && op <= 6'd25) begin
      ctl.alu     = 1'b1;
      ctl.use_imm = 1'b1;
      ctl.alu_sel = op[3:0] - 4'd10;
    end else if (op >= 6'd32 && op <= 6'd47) begin
      ctl.alu     = 1'b1;
      ctl.alu_sel = op[3:0];
    end else begin
      case (op)
        OP_LD_ABS: ctl.load = 1'b1;
        OP_LD_DSP: begin ctl.load = 1'b1; ctl.amode = AM_DISP; end
        OP_LD_IDX: begin ctl.load = 1'b1; ctl.amode = AM_IDX; end
        OP_ST_ABS: ctl.store = 1'b1;
        OP_ST_DSP: begin ctl.store = 1'b1; ctl.amode = AM_DISP; end
        OP_ST_IDX: begin ctl.store = 1'b1; ctl.amode = AM_IDX; end
        OP_JMP:    ctl.jmp = 1'b1;
        OP_JAL:    ctl.jal = 1'b1;
        OP_JT:     ctl.jt  = 1'b1;
        OP_JF:     ctl.jf  = 1'b1;
        OP_RET:    ctl.ret = 1'b1;
        OP_TRAP:   ctl.trap = 1'b1;
        OP_PUSH:   begin ctl.push = 1'b1; ctl.store = 1'b1; ctl.amode = AM_STACK; end
        OP_POP:    begin ctl.pop = 1'b1; ctl.amode = AM_STACK; end
        6'd0, 6'd5: ctl.bad = 1'b0;
        default:   ctl.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [3:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic is_cmp;
  assign is_cmp = (sel >= 4'd7) && (sel <= 4'd12);
  assign y = alu_fn(sel, a, b);

  always_comb begin
    if (is_cmp) AST_CMP_BOOL: assert (y[W-1:1] == '0); // R5
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];
endmodule

// File: rtl/tri_addr_core.sv
module tri_addr_core
  import core_pkg::*;
#(
  parameter int W = XLEN,
  localparam int RW = $clog2(NREGS)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic         halted,
  output logic         print_valid,
  output logic [W-1:0] print_data,
  output logic         illegal_op
);
  state_t state;
  logic [W-1:0] pc, ir, res_q, ea_q, sd_q, npc_q, aux_q, pd_q;
  logic pv_q, ill_q;

  logic [5:0]      f_op;
  logic [RW-1:0]   f_a, f_b, f_c;
  logic [DLEN-1:0] f_d;
  assign f_op = ir[31:26];
  assign f_a  = ir[25:21];
  assign f_b  = ir[20:16];
  assign f_d  = ir[15:0];
  assign f_c  = f_d[RW-1:0];

  ctl_t ctl;
  core_decode u_dec (.op(f_op), .ctl(ctl));

  logic [W-1:0] ra_v, rb_v, rc_v, d_sx, d_zx, opnd_b, alu_y;
  logic [W-1:0] ea, npc, wb_val, sdata;
  logic         rf_we;
  logic [RW-1:0] rf_wa;
  logic [W-1:0] rf_wd;

  core_regfile #(.W(W), .N(NREGS)) u_rf (
    .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra_a(f_a), .ra_b(f_b), .ra_c(f_c),
    .rd_a(ra_v), .rd_b(rb_v), .rd_c(rc_v)
  );

  assign d_sx   = {{(W-DLEN){f_d[DLEN-1]}}, f_d};
  assign d_zx   = {{(W-DLEN){1'b0}}, f_d};
  assign opnd_b = ctl.use_imm ? d_sx : rc_v;

  core_alu #(.W(W)) u_alu (.sel(ctl.alu_sel), .a(rb_v), .b(opnd_b), .y(alu_y));

  // effective address for the data access
  always_comb begin
    case (ctl.amode)
      AM_ABS:  ea = d_zx;
      AM_DISP: ea = d_sx + rb_v;
      AM_IDX:  ea = rb_v + rc_v;
      default: ea = ctl.push ? ra_v + 1'b1 : ra_v;
    endcase
  end

  logic redirect, taken;
  assign redirect = ctl.jmp | ctl.jal | ctl.jt | ctl.jf | ctl.ret;
  assign taken    = ctl.jmp | ctl.jal | (ctl.jt & (ra_v != '0)) | (ctl.jf & (ra_v == '0));
  assign npc      = ctl.ret ? ra_v : taken ? d_zx : pc + 1'b1;
  assign wb_val   = ctl.jal ? pc + 1'b1 : ctl.push ? ra_v + 1'b1 : alu_y;
  assign sdata    = ctl.push ? rb_v : ra_v;

  logic trap_halt, trap_print;
  assign trap_halt  = ctl.trap && (f_d == '0);
  assign trap_print = ctl.trap && (f_d == DLEN'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      res_q <= '0;
      ea_q  <= '0;
      sd_q  <= '0;
      npc_q <= '0;
      aux_q <= '0;
      pd_q  <= '0;
      pv_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      pv_q <= 1'b0;
      case (state)
        S_FETCH:  state <= S_DECODE;
        S_DECODE: begin
          ir    <= mem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          res_q <= wb_val;
          ea_q  <= ea;
          sd_q  <= sdata;
          npc_q <= npc;
          aux_q <= ra_v - 1'b1;
          if (ctl.bad) ill_q <= 1'b1;
          if (trap_print) begin
            pv_q <= 1'b1;
            pd_q <= ra_v;
          end
          state <= trap_halt ? S_HALT : S_MEM;
        end
        S_MEM: state <= S_WB;
        S_WB: begin
          pc    <= npc_q;
          state <= ctl.pop ? S_WB2 : S_FETCH;
        end
        S_WB2:   state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end

  // register write: first result, then the pop pointer decrement
  assign rf_we = ((state == S_WB) && (ctl.alu | ctl.load | ctl.jal | ctl.push | ctl.pop))
               || (state == S_WB2);
  assign rf_wa = (state == S_WB2) ? f_a : (ctl.pop ? f_b : f_a);
  assign rf_wd = (state == S_WB2) ? aux_q : ((ctl.load | ctl.pop) ? mem_rdata : res_q);

  assign mem_addr    = (state == S_MEM) ? ea_q : pc;
  assign mem_wdata   = sd_q;
  assign mem_we      = (state == S_MEM) && ctl.store;
  assign halted      = (state == S_HALT);
  assign print_valid = pv_q;
  assign print_data  = pd_q;
  assign illegal_op  = ill_q;

  AST_WE_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == S_MEM)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && !print_valid)); // R11
  AST_PRINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    print_valid |=> !print_valid); // R11
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> illegal_op); // R12
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WB) && !redirect) |=> (pc == $past(pc) + 1'b1)); // R9
  AST_FETCH_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_WB) && !ctl.pop) |=> (state == S_FETCH)); // R2
endmodule

// File: tb/sim_tri_addr_core.sv
module sim_tri_addr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, print_data;
  logic        mem_we, halted, print_valid, illegal_op;

  always #4 clk = ~clk;

  tri_addr_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .print_valid(print_valid), .print_data(print_data), .illegal_op(illegal_op)
  );

  // synchronous word memory with a loading port used during reset
  logic [31:0] mem [0:1023];
  logic        ld_en = 1'b0;
  logic [9:0]  ld_a = '0;
  logic [31:0] ld_d = '0;
  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input int op, input int a, input int b, input int d);
    return {op[5:0], a[4:0], b[4:0], d[15:0]};
  endfunction

  // scoreboard queues
  logic [31:0] pq_v[$];
  int          pq_g[$];
  string       pq_r[$];
  logic [31:0] sq_a[$];
  logic [31:0] sq_d[$];
  string       sq_r[$];

  task automatic exp_print(input logic [31:0] v, input int gap, input string req);
    pq_v.push_back(v); pq_g.push_back(gap); pq_r.push_back(req);
  endtask
  task automatic exp_store(input logic [31:0] a, input logic [31:0] d, input string req);
    sq_a.push_back(a); sq_d.push_back(d); sq_r.push_back(req);
  endtask

  int cyc = 0;
  int last_pc = -1;
  int n_print = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: prints and stores compared at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (print_valid) begin
        if (n_print == 0) chk(illegal_op == 1'b0, "R12", {31'd0, illegal_op}, 32'd0);
        if (pq_v.size() == 0) begin
          chk(1'b0, "R11", print_data, 32'd0);
        end else begin
          logic [31:0] v; int g; string r;
          v = pq_v.pop_front(); g = pq_g.pop_front(); r = pq_r.pop_front();
          chk(print_data == v, r, print_data, v);
          if (g != 0) chk((cyc - last_pc) == g, "R2", 32'(cyc - last_pc), 32'(g));
        end
        last_pc = cyc;
        n_print++;
      end
      if (mem_we) begin
        if (sq_a.size() == 0) begin
          chk(1'b0, "R8", mem_addr, 32'd0);
        end else begin
          logic [31:0] a, d; string r;
          a = sq_a.pop_front(); d = sq_d.pop_front(); r = sq_r.pop_front();
          chk(mem_addr == a, r, mem_addr, a);
          chk(mem_wdata == d, r, mem_wdata, d);
        end
      end
    end
  end

  logic [31:0] prog [0:63];

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    prog[0]  = ins(51, 0, 0, 1);       // print r0            R3
    prog[1]  = ins(10, 0, 0, 7);       // write to r0         R3
    prog[2]  = ins(51, 0, 0, 1);
    prog[3]  = ins(10, 1, 0, 16'hFFFB);// r1 = -5             R4
    prog[4]  = ins(51, 1, 0, 1);
    prog[5]  = ins(10, 2, 0, 3);       // r2 = 3
    prog[6]  = ins(34, 3, 1, 2);       // r3 = r1*r2
    prog[7]  = ins(51, 3, 0, 1);
    prog[8]  = ins(41, 4, 1, 2);       // r4 = r1 < r2        R5
    prog[9]  = ins(51, 4, 0, 1);
    prog[10] = ins(23, 5, 2, 4);       // r5 = r2 << 4
    prog[11] = ins(51, 5, 0, 1);
    prog[12] = ins(35, 6, 2, 0);       // div by zero         R6
    prog[13] = ins(51, 6, 0, 1);
    prog[14] = ins(47, 7, 1, 0);       // mod by zero
    prog[15] = ins(51, 7, 0, 1);
    prog[16] = ins(24, 8, 1, 28);      // logical shift right
    prog[17] = ins(51, 8, 0, 1);
    prog[18] = ins(13, 9, 1, 2);       // -5 / 2
    prog[19] = ins(51, 9, 0, 1);
    prog[20] = ins(3, 3, 0, 200);      // store absolute      R8
    prog[21] = ins(1, 10, 0, 200);     // load absolute       R7
    prog[22] = ins(51, 10, 0, 1);
    prog[23] = ins(10, 11, 0, 190);
    prog[24] = ins(4, 2, 11, 12);      // store disp -> 202
    prog[25] = ins(2, 12, 11, 12);     // load disp
    prog[26] = ins(51, 12, 0, 1);
    prog[27] = ins(10, 13, 0, 2);
    prog[28] = ins(49, 5, 11, 13);     // store index -> 192
    prog[29] = ins(48, 14, 11, 13);    // load index
    prog[30] = ins(51, 14, 0, 1);
    prog[31] = ins(8, 0, 0, 40);       // jt r0: not taken    R9
    prog[32] = ins(9, 0, 0, 34);       // jf r0: taken
    prog[33] = ins(51, 0, 0, 0);
    prog[34] = ins(7, 15, 0, 38);      // jal
    prog[35] = ins(51, 15, 0, 1);
    prog[36] = ins(6, 0, 0, 41);       // jmp
    prog[38] = ins(51, 2, 0, 1);
    prog[39] = ins(50, 15, 0, 0);      // ret
    prog[40] = ins(51, 0, 0, 0);
    prog[41] = ins(8, 2, 0, 43);       // jt taken
    prog[42] = ins(51, 0, 0, 0);
    prog[43] = ins(10, 16, 0, 300);    // stack pointer       R10
    prog[44] = ins(52, 16, 5, 0);
    prog[45] = ins(52, 16, 3, 0);
    prog[46] = ins(53, 16, 17, 0);
    prog[47] = ins(51, 17, 0, 1);
    prog[48] = ins(51, 16, 0, 1);
    prog[49] = ins(53, 16, 18, 0);
    prog[50] = ins(51, 18, 0, 1);
    prog[51] = ins(51, 16, 0, 1);
    prog[52] = ins(30, 1, 0, 0);       // undefined opcode    R12
    prog[53] = ins(51, 1, 0, 1);
    prog[54] = ins(0, 0, 0, 0);
    prog[55] = ins(5, 0, 0, 0);
    prog[56] = ins(51, 0, 0, 7);       // trap no-op          R11
    prog[57] = ins(51, 0, 0, 0);       // halt
    prog[58] = ins(51, 0, 0, 1);       // must never run

    exp_print(32'd0, 0, "R3");
    exp_print(32'd0, 10, "R3");
    exp_print(32'hFFFF_FFFB, 0, "R4");
    exp_print(-32'sd15, 0, "R4");
    exp_print(32'd1, 0, "R5");
    exp_print(32'd48, 0, "R4");
    exp_print(32'd0, 0, "R6");
    exp_print(-32'sd5, 0, "R6");
    exp_print(32'd15, 0, "R6");
    exp_print(-32'sd2, 0, "R6");
    exp_print(-32'sd15, 0, "R7");
    exp_print(32'd3, 0, "R7");
    exp_print(32'd48, 0, "R7");
    exp_print(32'd3, 0, "R9");
    exp_print(32'd35, 0, "R9");
    exp_print(-32'sd15, 0, "R10");
    exp_print(32'd301, 5, "R10");
    exp_print(32'd48, 11, "R10");
    exp_print(32'd300, 0, "R10");
    exp_print(-32'sd5, 0, "R12");
    exp_store(32'd200, -32'sd15, "R8");
    exp_store(32'd202, 32'd3, "R8");
    exp_store(32'd192, 32'd48, "R8");
    exp_store(32'd301, 32'd48, "R10");
    exp_store(32'd302, -32'sd15, "R10");

    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      ld_en = 1'b1; ld_a = 10'(i); ld_d = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    chk(mem_addr == 32'd0, "R1", mem_addr, 32'd0);
    chk({halted, illegal_op, print_valid, mem_we} == 4'b0, "R1",
        {28'd0, halted, illegal_op, print_valid, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_addr == 32'd0, "R1", mem_addr, 32'd0);

    while (!halted) @(negedge clk);
    begin
      logic [31:0] hold_a;
      hold_a = mem_addr;
      repeat (30) @(negedge clk);
      chk(mem_addr == hold_a, "R11", mem_addr, hold_a);
    end
    chk(halted == 1'b1, "R11", {31'd0, halted}, 32'd1);
    chk(illegal_op == 1'b1, "R12", {31'd0, illegal_op}, 32'd1);
    chk(pq_v.size() == 0, "R9", 32'(pq_v.size()), 32'd0);
    chk(sq_a.size() == 0, "R8", 32'(sq_a.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R11: watchdog expired, actual=running expected=halted");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule